// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six control-register access operations of a 32-bit integer core against a small built-in bank of 32-bit control and status registers. Each request names an operation (plain write, bit set or bit clear), a 12-bit register address and a source. The source is either the value of a general-purpose register or a 5-bit immediate that is zero-extended to 32 bits. Two flags tell the unit whether the destination register is x0 and whether the source register is x0.

The unit returns the register's previous contents in the same cycle as the request, so the core can write them to its destination register. The new contents are stored on the next rising clock edge. Every bank entry has a fixed reset value and a fixed per-bit writability mask. Bits outside the mask never change. The unit raises an illegal-instruction flag for an unknown address, for an undefined operation code, and for any attempt to change a register in the read-only address range. A read-only register can still be read on its own.

The unit also drives two strobes. One marks a register read, which is the point where a read side effect would happen. The other marks a register write. These strobes let the surrounding pipeline see when an access is suppressed.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation code `req_op[1:0]=01` is a plain write. It returns the old register value on `rd_data` in the request cycle. From the next clock edge the register holds `(old & ~mask) | (src & mask)`.
- R2: A plain write with `rd_is_x0=1` performs no read. `rd_read` stays 0 and `rd_data` is 0, but the write still happens and `wr_fire` is 1.
- R3: Operation code `req_op[1:0]=10` is a set. It returns the old value, and the register becomes `old | (src & mask)`.
- R4: Operation code `req_op[1:0]=11` is a clear. It returns the old value, and the register becomes `old & ~(src & mask)`.
- R5: Bits whose mask bit is 0 keep their reset value under any sequence of requests.
- R6: With `req_op[2]=1` the source is `uimm` zero-extended to 32 bits, and `rs1_value` and `src_is_x0` are ignored. With `req_op[2]=0` the source is `rs1_value`.
- R7: A set or clear whose source is x0 (register form with `src_is_x0=1`) or a zero immediate performs no write (`wr_fire=0`). It still reads and returns the value.
- R8: An address outside the bank raises `illegal`. An illegal request reads nothing, writes nothing and returns 0.
- R9: A request that would write an address whose bits [11:10] are 11 raises `illegal`. A pure read of such an address (a set or clear with a zero source) is allowed.
- R10: The bank holds four registers, given here as address, reset value and mask:
  - 0x300: reset 0x00001800, mask 0x00001888
  - 0x305: reset 0x00000100, mask 0xFFFFFFFC
  - 0x340: reset 0x00000000, mask 0xFFFFFFFF
  - 0xF11: reset 0x00000A5A, mask 0x00000000
- R11: `rd_data`, `rd_read`, `wr_fire` and `illegal` are combinational in the request cycle. With `req_valid=0` they are all 0, and no register changes unless `wr_fire` was 1 at the preceding edge.
- R12: Operation codes with `req_op[1:0]=00` are undefined and raise `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Bit 2: immediate source; bits 1:0: 01 write, 10 set, 11 clear |
| req_addr | input | 12 | Register address |
| rs1_value | input | 32 | Source register value |
| uimm | input | 5 | Immediate source |
| rd_is_x0 | input | 1 | Destination register is x0 |
| src_is_x0 | input | 1 | Source register is x0 |
| rd_data | output | 32 | Previous register value, 0 when no read |
| rd_read | output | 1 | Register read performed |
| wr_fire | output | 1 | Register write performed at next edge |
| illegal | output | 1 | Illegal-instruction exception |

## Verification
The returned value and the three flags are due in the cycle of the request, and the stored result is due one edge later. The bench applies each request just after a falling edge and samples a quarter period later, before the rising edge that commits it. The effect of a write is therefore checked through the value the next request returns. A sweep covers every address, every operation code, both destination flags, both source flags and zero and non-zero sources against a bench-side model of the bank.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  localparam int XLEN    = 32;
  localparam int ADDR_W  = 12;
  localparam int UIMM_W  = 5;
  localparam int NUM_CSR = 4;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SET   = 2'b10,
    KIND_CLEAR = 2'b11
  } kind_e;

  // index 0 is the lowest entry
  localparam logic [NUM_CSR-1:0][ADDR_W-1:0] BANK_ADDR =
    {12'hF11, 12'h340, 12'h305, 12'h300};
  localparam logic [NUM_CSR-1:0][XLEN-1:0] BANK_MASK =
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h0000_1888};
  localparam logic [NUM_CSR-1:0][XLEN-1:0] BANK_RESET =
    {32'h0000_0A5A, 32'h0000_0000, 32'h0000_0100, 32'h0000_1800};
endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
  import csr_rmw_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int N   = NUM_CSR,
  parameter int I_W = UIMM_W,
  parameter logic [N-1:0][A_W-1:0] ADDRS = BANK_ADDR
) (
  input  logic           valid,
  input  logic [2:0]     op,
  input  logic [A_W-1:0] addr,
  input  logic [I_W-1:0] uimm,
  input  logic           rd_is_x0,
  input  logic           src_is_x0,
  output logic [N-1:0]   hit,
  output kind_e          kind,
  output logic           do_read,
  output logic           do_write,
  output logic           is_illegal
);
  logic any_hit;
  logic src_zero;
  logic wants_write;
  logic ro_space;

  for (genvar i = 0; i < N; i++) begin : g_match
    assign hit[i] = (addr == ADDRS[i]);
  end

  always_comb begin
    any_hit     = |hit;
    kind        = kind_e'(op[1:0]);
    src_zero    = op[2] ? (uimm == '0) : src_is_x0;
    ro_space    = (addr[A_W-1 -: 2] == 2'b11);
    wants_write = (kind == KIND_WRITE) ||
                  (((kind == KIND_SET) || (kind == KIND_CLEAR)) && !src_zero);
    is_illegal  = valid && ((kind == KIND_NONE) || !any_hit || (wants_write && ro_space));
    do_write    = valid && !is_illegal && wants_write;
    do_read     = valid && !is_illegal && !((kind == KIND_WRITE) && rd_is_x0);
  end
endmodule

// File: rtl/csr_rmw_update.sv
module csr_rmw_update
  import csr_rmw_pkg::*;
#(
  parameter int W = XLEN
) (
  input  kind_e        kind,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic [W-1:0] new_val
);
  logic [W-1:0] eff;

  always_comb begin
    eff = src & mask;
    unique case (kind)
      KIND_WRITE: new_val = (old_val & ~mask) | eff;
      KIND_SET:   new_val = old_val | eff;
      KIND_CLEAR: new_val = old_val & ~eff;
      default:    new_val = old_val;
    endcase
  end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank
  import csr_rmw_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NUM_CSR,
  parameter logic [N-1:0][W-1:0] MASKS  = BANK_MASK,
  parameter logic [N-1:0][W-1:0] RESETS = BANK_RESET
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        hit,
  input  logic                wr_en,
  input  logic [W-1:0]        wr_val,
  output logic [W-1:0]        sel_val,
  output logic [W-1:0]        sel_mask,
  output logic [N-1:0][W-1:0] state
);
  logic [N-1:0][W-1:0] state_d;
  logic [N-1:0]        load;

  for (genvar i = 0; i < N; i++) begin : g_entry
    always_comb begin
      load[i]    = wr_en && hit[i];
      state_d[i] = load[i] ? wr_val : state[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state[i] <= RESETS[i];
      else if (load[i]) state[i] <= state_d[i];
    end
  end

  always_comb begin
    sel_val  = '0;
    sel_mask = '0;
    for (int i = 0; i < N; i++) begin
      sel_val  = sel_val  | (state[i] & {W{hit[i]}});
      sel_mask = sel_mask | (MASKS[i] & {W{hit[i]}});
    end
  end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int A_W = ADDR_W,
  parameter int I_W = UIMM_W,
  parameter int N   = NUM_CSR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_op,
  input  logic [A_W-1:0] req_addr,
  input  logic [W-1:0]   rs1_value,
  input  logic [I_W-1:0] uimm,
  input  logic           rd_is_x0,
  input  logic           src_is_x0,
  output logic [W-1:0]   rd_data,
  output logic           rd_read,
  output logic           wr_fire,
  output logic           illegal
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [N-1:0]        hit;
  kind_e               kind;
  logic [W-1:0]        src;
  logic [W-1:0]        old_val;
  logic [W-1:0]        old_mask;
  logic [W-1:0]        new_val;
  logic [N-1:0][W-1:0] csr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign src = req_op[2] ? {{(W-I_W){1'b0}}, uimm} : rs1_value;

  csr_rmw_decode #(.A_W(A_W), .N(N), .I_W(I_W)) u_dec (
    .valid(req_valid), .op(req_op), .addr(req_addr), .uimm(uimm),
    .rd_is_x0(rd_is_x0), .src_is_x0(src_is_x0),
    .hit(hit), .kind(kind), .do_read(rd_read), .do_write(wr_fire),
    .is_illegal(illegal)
  );

  csr_rmw_bank #(.W(W), .N(N)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .wr_en(wr_fire),
    .wr_val(new_val), .sel_val(old_val), .sel_mask(old_mask), .state(csr_q)
  );

  csr_rmw_update #(.W(W)) u_upd (
    .kind(kind), .old_val(old_val), .src(src), .mask(old_mask), .new_val(new_val)
  );

  assign rd_data = rd_read ? old_val : '0;
endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker
  import csr_rmw_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int A_W = ADDR_W,
  parameter int N   = NUM_CSR
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                req_valid,
  input logic [2:0]          req_op,
  input logic [A_W-1:0]      req_addr,
  input logic                rd_is_x0,
  input logic [W-1:0]        rd_data,
  input logic                rd_read,
  input logic                wr_fire,
  input logic                illegal,
  input logic [N-1:0][W-1:0] csr_q
);
  p_illegal_inert_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (!wr_fire && !rd_read && rd_data == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |-> (!illegal && !rd_read && !wr_fire));

  p_skip_read_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_op[1:0] == 2'b01 && rd_is_x0) |-> !rd_read);

  p_zero_without_read_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_read |-> (rd_data == '0));

  p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_fire |=> $stable(csr_q));

  p_ro_never_written_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_addr[A_W-1 -: 2] == 2'b11) |-> !wr_fire);

  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((csr_q ^ BANK_RESET) & ~BANK_MASK) == '0);
endmodule

bind csr_rmw_unit csr_rmw_checker #(.W(W), .A_W(A_W), .N(N)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_valid(req_valid), .req_op(req_op),
  .req_addr(req_addr), .rd_is_x0(rd_is_x0), .rd_data(rd_data), .rd_read(rd_read),
  .wr_fire(wr_fire), .illegal(illegal), .csr_q(csr_q)
);

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [11:0] req_addr;
  logic [31:0] rs1_value;
  logic [4:0]  uimm;
  logic        rd_is_x0;
  logic        src_is_x0;
  logic [31:0] rd_data;
  logic        rd_read;
  logic        wr_fire;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the bank, from R10
  logic [11:0] m_addr  [4] = '{12'h300, 12'h305, 12'h340, 12'hF11};
  logic [31:0] m_mask  [4] = '{32'h0000_1888, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h0};
  logic [31:0] m_reset [4] = '{32'h0000_1800, 32'h0000_0100, 32'h0, 32'h0000_0A5A};
  logic [31:0] m_val   [4];

  csr_rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .rs1_value(rs1_value), .uimm(uimm), .rd_is_x0(rd_is_x0),
    .src_is_x0(src_is_x0), .rd_data(rd_data), .rd_read(rd_read),
    .wr_fire(wr_fire), .illegal(illegal)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic txn(input logic [11:0] a, input logic [2:0] op, input bit rdx0,
                     input bit srcx0, input logic [31:0] rs1, input logic [4:0] im,
                     input string force_tag);
    int idx;
    bit imm, intend, ro, e_ill, e_rd, e_wr;
    logic [31:0] src, e_data, old, eff, nv;
    string tag;
    idx = -1;
    for (int i = 0; i < 4; i++) if (m_addr[i] == a) idx = i;
    imm    = op[2];
    src    = imm ? {27'd0, im} : rs1;
    intend = (op[1:0] == 2'b01) ||
             ((op[1:0] != 2'b00) && (imm ? (im != 0) : !srcx0));
    ro     = (a[11:10] == 2'b11);
    e_ill  = (op[1:0] == 2'b00) || (idx < 0) || (intend && ro);
    e_rd   = !e_ill && !((op[1:0] == 2'b01) && rdx0);
    e_wr   = !e_ill && intend;
    old    = (idx >= 0) ? m_val[idx] : 32'd0;
    e_data = e_rd ? old : 32'd0;
    if (e_ill)                 tag = (op[1:0] == 2'b00) ? "R12" : (idx < 0) ? "R8" : "R9";
    else if (op[1:0] == 2'b01) tag = rdx0 ? "R2" : "R1";
    else if (!intend)          tag = ro ? "R9" : "R7";
    else if (imm)              tag = "R6";
    else                       tag = (op[1:0] == 2'b10) ? "R3" : "R4";
    if (force_tag != "") tag = force_tag;

    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; rs1_value = rs1; uimm = im;
    rd_is_x0 = rdx0; src_is_x0 = srcx0;
    #5;
    check(tag, "rd_data", rd_data, e_data);
    check(tag, "illegal", {31'd0, illegal}, {31'd0, e_ill});
    check(tag, "rd_read", {31'd0, rd_read}, {31'd0, e_rd});
    check(tag, "wr_fire", {31'd0, wr_fire}, {31'd0, e_wr});
    if (e_wr) begin
      eff = src & m_mask[idx];
      case (op[1:0])
        2'b01:   nv = (old & ~m_mask[idx]) | eff;
        2'b10:   nv = old | eff;
        default: nv = old & ~eff;
      endcase
      m_val[idx] = nv;
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 0; req_op = 3'b000; req_addr = '0; rs1_value = '0; uimm = '0;
    rd_is_x0 = 0; src_is_x0 = 0;
    #5;
    // R11: idle request produces no activity
    check("R11", "idle flags", {29'd0, illegal, rd_read, wr_fire}, 32'd0);
  endtask

  function automatic logic [31:0] mix(input int k);
    logic [31:0] x;
    x = 32'h9E37_79B9 * (k + 1);
    return x ^ (x >> 13) ^ (x << 7);
  endfunction

  initial begin
    logic [11:0] sweep_addr [6] = '{12'h300, 12'h305, 12'h340, 12'hF11, 12'h301, 12'hC00};
    int k;
    for (int i = 0; i < 4; i++) m_val[i] = m_reset[i];
    req_valid = 0; req_op = 0; req_addr = 0; rs1_value = 0; uimm = 0;
    rd_is_x0 = 0; src_is_x0 = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R10: reset values via pure reads (set, source x0)
    for (int i = 0; i < 4; i++) txn(m_addr[i], 3'b010, 0, 1, 32'd0, 5'd0, "R10");
    go_idle();

    // R5: all-ones write lands only on writable bits
    txn(12'h300, 3'b001, 0, 0, 32'hFFFF_FFFF, 5'd0, "R5");
    txn(12'h300, 3'b010, 0, 1, 32'd0, 5'd0, "R5");
    // R11: old value now, new value on the next request
    txn(12'h340, 3'b001, 0, 0, 32'hDEAD_BEEF, 5'd0, "R11");
    txn(12'h340, 3'b001, 0, 0, 32'h1234_5678, 5'd0, "R11");
    check("R11", "next value", rd_data, 32'hDEAD_BEEF);
    // R6: immediate zero-extended, rs1 ignored
    txn(12'h340, 3'b101, 0, 0, 32'hFFFF_FFFF, 5'h1F, "R6");
    txn(12'h340, 3'b010, 0, 1, 32'd0, 5'd0, "R6");
    check("R6", "zext imm", rd_data, 32'h0000_001F);
    go_idle();

    k = 0;
    for (int ai = 0; ai < 6; ai++)
      for (int op = 0; op < 8; op++)
        for (int rdx = 0; rdx < 2; rdx++)
          for (int sx = 0; sx < 2; sx++)
            for (int s = 0; s < 4; s++) begin
              logic [31:0] r;
              r = (sx == 1 || s == 0) ? 32'd0 : mix(k);
              txn(sweep_addr[ai], op[2:0], rdx[0], sx[0], r,
                  (s == 0) ? 5'd0 : mix(k + 7)[4:0], "");
              k++;
            end
    go_idle();

    // final readback, R5 fixed bits kept
    for (int i = 0; i < 4; i++) txn(m_addr[i], 3'b110, 0, 0, 32'd0, 5'd0, "R5");
    go_idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule